// File: doc/BRIEF.md
# Edge-Triggered Pin Interrupt Bank

This block collects edge events from a bank of filtered input pins and turns them into a single interrupt line. Each pin carries a two-bit trigger code, taken from its pin control word, that selects rising, falling or both-edge detection. A code of zero turns detection off. A detected edge sets a sticky bit in the pending register. The bit stays set until software writes a one to it.

Software controls masking through two word addresses. A write to the mask address sets mask bits. A write to the unmask address clears them. The bank interrupt is high while any pending bit is set and its pin is unmasked. Pending bits are still captured while a pin is masked, so unmasking a pin that already has a pending event raises the interrupt at once. Level-sensitive triggering is not provided.

Register access is a simple single-cycle request bus. Reads return data one cycle after the request. The bank index parameter places the three registers at the pending base 0x080, the mask base 0x0A0 and the unmask base 0x0C0, each plus four times the bank index.

Top module: `gpio_edge_irq_bank`

## Requirements
- R1: After reset, every pending bit is 0, every mask bit is 1 and irq_o is 0.
- R2: Trigger code 1 (pin control bits [1:0] of that pin's field) sets the pin's pending bit on a 0-to-1 change of the pin only.
- R3: Trigger code 2 sets the pending bit on a 1-to-0 change of the pin only.
- R4: Trigger code 3 sets the pending bit on either change of the pin.
- R5: Trigger code 0 never sets the pending bit, whatever the pin does.
- R6: Writing the pending register (0x080 + 4*bank) clears each bit written as 1 and leaves every bit written as 0 unchanged.
- R7: When an edge and a clear of the same pending bit fall in the same cycle, the bit ends up set.
- R8: Writing the mask register (0x0A0 + 4*bank) sets each mask bit written as 1 and leaves the other mask bits unchanged.
- R9: Writing the unmask register (0x0C0 + 4*bank) clears each mask bit written as 1 and leaves the other mask bits unchanged.
- R10: irq_o is 1 exactly while some pending bit is set whose mask bit is 0, and it follows register changes with no added delay.
- R11: Edges on a masked pin still set its pending bit, and unmasking that pin raises irq_o.
- R12: A read returns data on rdata_o one cycle after the request. The pending and mask addresses return those registers, the unmask address returns the current mask, and any other address returns 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| req_i | input | 1 | Register access request |
| we_i | input | 1 | 1 for write, 0 for read |
| addr_i | input | 12 | Byte address |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data, valid the cycle after a read request |
| trig_mode_i | input | 64 | Two-bit trigger code per pin, pin k at bits [2k+1:2k] |
| pin_i | input | 32 | Filtered pin levels |
| irq_o | output | 1 | Bank interrupt |

## Verification
A pin change that is applied before a clock edge is registered at that edge. The pending bit, and irq_o if it follows, are updated after that edge. A write takes effect at the edge on which it is presented, and irq_o reflects it straight after that edge. A read request presented at one edge returns its data after that same edge, and the data holds until the next read. The bench drives every input on the falling clock edge and advances exactly one rising edge per stimulus. It samples on the next falling edge, so each check lands in the first cycle where the result is due.

// File: rtl/gpio_edge_irq_pkg.sv
package gpio_edge_irq_pkg;
  typedef enum logic [1:0] {
    TRIG_OFF  = 2'd0,
    TRIG_RISE = 2'd1,
    TRIG_FALL = 2'd2,
    TRIG_BOTH = 2'd3
  } trig_e;

  localparam int unsigned PEND_BASE   = 32'h080;
  localparam int unsigned MASK_BASE   = 32'h0A0;
  localparam int unsigned UNMASK_BASE = 32'h0C0;

  function automatic int unsigned bank_off(int unsigned base, int unsigned bank);
    return base + (bank << 2);
  endfunction
endpackage

// File: rtl/gpio_edge_detect.sv
module gpio_edge_detect
  import gpio_edge_irq_pkg::*;
#(
  parameter int unsigned NUM_PINS = 32
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic [NUM_PINS-1:0]   pin_i,
  input  logic [2*NUM_PINS-1:0] mode_i,
  output logic [NUM_PINS-1:0]   hit_o
);
  logic [NUM_PINS-1:0] pin_q;
  logic                armed_q;

  // first cycle after reset only loads history, so a pin already high is no edge
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pin_q   <= '0;
      armed_q <= 1'b0;
    end else begin
      pin_q   <= pin_i;
      armed_q <= 1'b1;
    end
  end

  for (genvar g = 0; g < NUM_PINS; g++) begin : g_pin
    trig_e mode;
    assign mode = trig_e'(mode_i[2*g +: 2]);
    always_comb begin
      unique case (mode)
        TRIG_RISE: hit_o[g] = armed_q &  pin_i[g] & ~pin_q[g];
        TRIG_FALL: hit_o[g] = armed_q & ~pin_i[g] &  pin_q[g];
        TRIG_BOTH: hit_o[g] = armed_q & (pin_i[g] ^ pin_q[g]);
        default:   hit_o[g] = 1'b0;
      endcase
    end
  end
endmodule

// File: rtl/gpio_pend_reg.sv
module gpio_pend_reg #(
  parameter int unsigned NUM_PINS = 32
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [NUM_PINS-1:0] hit_i,
  input  logic                clr_we_i,
  input  logic [NUM_PINS-1:0] clr_data_i,
  output logic [NUM_PINS-1:0] pend_o
);
  logic [NUM_PINS-1:0] pend_q, clr_eff;

  assign clr_eff = clr_we_i ? clr_data_i : '0;

  // set dominates clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pend_q <= '0;
    else         pend_q <= (pend_q & ~clr_eff) | hit_i;
  end

  assign pend_o = pend_q;

  p_sticky_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> ((pend_q & $past(pend_q & ~clr_eff)) == $past(pend_q & ~clr_eff)));

  p_edge_wins_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|hit_i) |=> ((pend_q & $past(hit_i)) == $past(hit_i)));
endmodule

// File: rtl/gpio_mask_reg.sv
module gpio_mask_reg #(
  parameter int unsigned NUM_PINS = 32
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                set_we_i,
  input  logic                clr_we_i,
  input  logic [NUM_PINS-1:0] data_i,
  output logic [NUM_PINS-1:0] mask_o
);
  logic [NUM_PINS-1:0] mask_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       mask_q <= '1;
    else if (set_we_i) mask_q <= mask_q | data_i;
    else if (clr_we_i) mask_q <= mask_q & ~data_i;
  end

  assign mask_o = mask_q;

  p_mask_set_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    set_we_i |=> ((mask_q & $past(data_i)) == $past(data_i)));

  p_mask_clr_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_we_i && !set_we_i) |=> ((mask_q & $past(data_i)) == '0));
endmodule

// File: rtl/gpio_edge_irq_bank.sv
module gpio_edge_irq_bank
  import gpio_edge_irq_pkg::*;
#(
  parameter int unsigned NUM_PINS = 32,
  parameter int unsigned ADDR_W   = 12,
  parameter int unsigned BANK_IDX = 0
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  req_i,
  input  logic                  we_i,
  input  logic [ADDR_W-1:0]     addr_i,
  input  logic [NUM_PINS-1:0]   wdata_i,
  output logic [NUM_PINS-1:0]   rdata_o,
  input  logic [2*NUM_PINS-1:0] trig_mode_i,
  input  logic [NUM_PINS-1:0]   pin_i,
  output logic                  irq_o
);
  localparam logic [ADDR_W-1:0] PEND_ADDR   = ADDR_W'(bank_off(PEND_BASE, BANK_IDX));
  localparam logic [ADDR_W-1:0] MASK_ADDR   = ADDR_W'(bank_off(MASK_BASE, BANK_IDX));
  localparam logic [ADDR_W-1:0] UNMASK_ADDR = ADDR_W'(bank_off(UNMASK_BASE, BANK_IDX));

  logic [NUM_PINS-1:0] hit, pend, mask, rdata_q, rd_mux;
  logic wr, rd, hit_pend, hit_mask, hit_unmask;

  assign wr         = req_i &  we_i;
  assign rd         = req_i & ~we_i;
  assign hit_pend   = (addr_i == PEND_ADDR);
  assign hit_mask   = (addr_i == MASK_ADDR);
  assign hit_unmask = (addr_i == UNMASK_ADDR);

  gpio_edge_detect #(.NUM_PINS(NUM_PINS)) u_edge (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .pin_i  (pin_i),
    .mode_i (trig_mode_i),
    .hit_o  (hit)
  );

  gpio_pend_reg #(.NUM_PINS(NUM_PINS)) u_pend (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .hit_i      (hit),
    .clr_we_i   (wr & hit_pend),
    .clr_data_i (wdata_i),
    .pend_o     (pend)
  );

  gpio_mask_reg #(.NUM_PINS(NUM_PINS)) u_mask (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .set_we_i (wr & hit_mask),
    .clr_we_i (wr & hit_unmask),
    .data_i   (wdata_i),
    .mask_o   (mask)
  );

  always_comb begin
    rd_mux = '0;
    if (hit_pend)                   rd_mux = pend;
    else if (hit_mask || hit_unmask) rd_mux = mask;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)  rdata_q <= '0;
    else if (rd)  rdata_q <= rd_mux;
  end

  assign rdata_o = rdata_q;
  assign irq_o   = |(pend & ~mask);

  p_unmask_read_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd && hit_unmask) |=> (rdata_o == $past(mask)));

  p_irq_quiet_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pend == '0) |-> !irq_o);
endmodule

// File: tb/gpio_edge_irq_bank_tb.sv
module gpio_edge_irq_bank_tb;
  localparam int N = 32;
  localparam logic [11:0] A_PEND = 12'h080, A_MASK = 12'h0A0, A_UNMASK = 12'h0C0;

  logic          clk = 1'b0, rst_ni = 1'b0;
  logic          req = 1'b0, we = 1'b0;
  logic [11:0]   addr = '0;
  logic [N-1:0]  wdata = '0, rdata, pins = '0;
  logic [2*N-1:0] modes = '0;
  logic          irq;
  int checks = 0, errors = 0;

  always #2 clk = ~clk;

  gpio_edge_irq_bank u_dut (
    .clk_i(clk), .rst_ni(rst_ni), .req_i(req), .we_i(we), .addr_i(addr),
    .wdata_i(wdata), .rdata_o(rdata), .trig_mode_i(modes), .pin_i(pins), .irq_o(irq)
  );

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %08h expected %08h", tag, act, exp);
    end
  endtask

  task automatic wr(logic [11:0] a, logic [31:0] d);
    @(negedge clk); req = 1; we = 1; addr = a; wdata = d;
    @(posedge clk);
    @(negedge clk); req = 0; we = 0;
  endtask

  task automatic rd(logic [11:0] a, output logic [31:0] d);
    @(negedge clk); req = 1; we = 0; addr = a;
    @(posedge clk);
    @(negedge clk); req = 0; d = rdata;
  endtask

  task automatic drive_pins(logic [N-1:0] v);
    @(negedge clk); pins = v;
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic t_reset;
    logic [31:0] d;
    check("R1 irq", {31'b0, irq}, 32'h0);
    rd(A_PEND, d);   check("R1 pending", d, 32'h0);
    rd(A_MASK, d);   check("R1 mask", d, 32'hFFFF_FFFF);
    rd(A_UNMASK, d); check("R12 unmask reads mask", d, 32'hFFFF_FFFF);
    rd(12'h004, d);  check("R12 other addr", d, 32'h0);
  endtask

  task automatic t_edges;
    logic [31:0] d;
    wr(A_UNMASK, 32'hFFFF_FFFF);
    rd(A_MASK, d); check("R9 unmask all", d, 32'h0);
    drive_pins(32'h0000_000F);
    rd(A_PEND, d); check("R2 R4 R5 rise", d, 32'h5);
    check("R10 irq on", {31'b0, irq}, 32'h1);
    wr(A_PEND, 32'h5);
    rd(A_PEND, d); check("R6 clear", d, 32'h0);
    check("R10 irq off", {31'b0, irq}, 32'h0);
    drive_pins(32'h0);
    rd(A_PEND, d); check("R3 R4 fall", d, 32'h6);
    wr(A_PEND, 32'h2);
    rd(A_PEND, d); check("R6 partial clear", d, 32'h4);
    wr(A_PEND, 32'h4);
  endtask

  task automatic t_collision;
    logic [31:0] d;
    @(negedge clk); pins = 32'h1; req = 1; we = 1; addr = A_PEND; wdata = 32'h1;
    @(posedge clk);
    @(negedge clk); req = 0; we = 0;
    rd(A_PEND, d); check("R7 edge wins", d, 32'h1);
    wr(A_PEND, 32'h1);
  endtask

  task automatic t_masking;
    logic [31:0] d;
    wr(A_MASK, 32'h1);
    rd(A_UNMASK, d); check("R8 mask set", d, 32'h1);
    drive_pins(32'h0);
    drive_pins(32'h1);
    rd(A_PEND, d); check("R11 pending while masked", d, 32'h1);
    check("R11 irq held off", {31'b0, irq}, 32'h0);
    @(negedge clk); req = 1; we = 1; addr = A_UNMASK; wdata = 32'h1;
    @(posedge clk);
    @(negedge clk); req = 0; we = 0;
    check("R11 unmask raises irq", {31'b0, irq}, 32'h1);
    wr(A_MASK, 32'h2);
    rd(A_MASK, d); check("R8 zero bits kept", d, 32'h2);
  endtask

  initial begin
    // pin0 rise, pin1 fall, pin2 both, pin3 off
    modes = '0;
    modes[1:0] = 2'd1; modes[3:2] = 2'd2; modes[5:4] = 2'd3; modes[7:6] = 2'd0;
    repeat (3) @(negedge clk);
    rst_ni = 1;
    @(negedge clk);
    t_reset();
    t_edges();
    t_collision();
    t_masking();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule